// File: doc/BRIEF.md
# Overlapped RAM and Register-Space Decoder

This block sits between a CPU core and two on-chip storage spaces that share one 8-bit internal address range. A 256-byte data RAM lives inside the block. A special-register space lives outside it and is reached through a simple strobe port. The lower half of the address range, 00h to 7Fh, always reaches the RAM. The upper half, 80h to FFh, is ambiguous. An access made with direct addressing goes to the register space. An access made with indirect addressing goes to the upper 128 bytes of RAM, which are storage of their own and distinct from the register space.

The CPU presents an address, read and write strobes, write data and an indirect-mode flag in one cycle. The block steers the access to exactly one of the two spaces. It returns the read byte one cycle later, whichever space supplied it. The register space is only partly populated, and a parameter mask marks which register addresses exist. A read from an empty register address returns a fixed fill byte. A write to an empty register address is discarded and reported on a one-cycle debug flag.

Top module: `ovl_space_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpuRdData` is 00h and `dropWr` is 0.
- R2: An access with address bit 7 clear goes to RAM location `cpuAddr` in either mode, and never raises `regRd` or `regWr`.
- R3: An access with address bit 7 set and `cpuIndirect` = 1 goes to RAM location `cpuAddr` (the upper 128 bytes). It never raises `regRd` or `regWr`, and it is unaffected by register-space writes to the same address.
- R4: An access with address bit 7 set, `cpuIndirect` = 0 and the mask bit `OCC_MASK[cpuAddr[6:0]]` set raises `regRd`/`regWr` in the same cycle. `regAddr` = `cpuAddr[6:0]` and `regWrData` = `cpuWrData`, and the RAM is left untouched.
- R5: Read data appears on `cpuRdData` in the cycle after the read strobe, for both spaces. It holds its value through cycles that carry no read.
- R6: A direct read of an upper address whose mask bit is clear returns `FILL_VALUE` (default 00h) and does not raise `regRd`.
- R7: A direct write to an upper address whose mask bit is clear raises no write strobe and changes no stored byte. `dropWr` is 1 for exactly the following cycle.
- R8: No cycle raises both a RAM write and `regWr`, and `regWr` is raised only for an occupied register address.
- R9: When read and write are both asserted in one cycle, both go to the same target. A RAM read in that cycle returns the byte stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 8 | Internal address of the access |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe |
| cpuWrData | input | 8 | Write data |
| cpuIndirect | input | 1 | 1 = indirect addressing, 0 = direct addressing |
| cpuRdData | output | 8 | Read data, one cycle after the read |
| regRd | output | 1 | Read strobe to the register space |
| regWr | output | 1 | Write strobe to the register space |
| regAddr | output | 7 | Register offset within 80h..FFh |
| regWrData | output | 8 | Write data to the register space |
| regRdData | input | 8 | Register read data, valid in the cycle of `regRd` |
| dropWr | output | 1 | Pulses the cycle after a write to an empty register address |

## Verification
The hardest case to reach is a single upper address that holds different values in both spaces, followed by interleaved reads in each mode. Only this case shows that the upper RAM and the register space are truly separate. The stimulus writes distinct bytes to the same upper addresses in indirect and in direct mode, then reads them back in alternating modes. It also covers occupied and empty register addresses, and cycles where read and write coincide. The bench then runs a long random mix of modes and addresses against a behavioural model that is compared every clock.

// File: rtl/ovl_dec_pkg.sv
package ovl_dec_pkg;
  typedef struct packed {
    logic ramWr;
    logic ramRd;
    logic regWr;
    logic regRd;
    logic regSel;
    logic dropWr;
  } accessStrobes_t;
endpackage

// File: rtl/ovl_dec_ctrl.sv
module ovl_dec_ctrl
  import ovl_dec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [2**(ADDR_W-1)-1:0] OCC_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              cpuIndirect,
  output accessStrobes_t    strobes
);
  localparam int OFS_W = ADDR_W - 1;

  logic upperHalf, toRegSpace, occupied;

  always_comb begin
    upperHalf  = cpuAddr[ADDR_W-1];
    toRegSpace = upperHalf & ~cpuIndirect;
    occupied   = OCC_MASK[cpuAddr[OFS_W-1:0]];
    strobes.ramWr  = cpuWr & ~toRegSpace;
    strobes.ramRd  = cpuRd & ~toRegSpace;
    strobes.regWr  = cpuWr & toRegSpace & occupied;
    strobes.regRd  = cpuRd & toRegSpace & occupied;
    strobes.regSel = cpuRd & toRegSpace;
    strobes.dropWr = cpuWr & toRegSpace & ~occupied;
  end

  // R8
  one_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.ramWr && strobes.regWr));
  // R2
  lower_never_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[ADDR_W-1] |-> !strobes.regRd && !strobes.regWr);
  // R3
  indirect_never_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIndirect |-> !strobes.regRd && !strobes.regWr);
endmodule

// File: rtl/ovl_dec_dpath.sv
module ovl_dec_dpath
  import ovl_dec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobes_t    strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              dropWr
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] ramArr [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.ramWr) ramArr[cpuAddr] <= cpuWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdData <= '0;
      dropWr    <= 1'b0;
    end else begin
      dropWr <= strobes.dropWr;
      if (strobes.ramRd)
        cpuRdData <= ramArr[cpuAddr];
      else if (strobes.regSel)
        cpuRdData <= strobes.regRd ? regRdData : FILL_VALUE;
    end
  end

  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R5
  hold_without_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(strobes.ramRd || strobes.regSel) |-> $stable(cpuRdData));
  // R7
  drop_flag_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> dropWr == $past(strobes.dropWr));
  // R6
  empty_read_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regSel && !strobes.regRd |=> cpuRdData == FILL_VALUE);
endmodule

// File: rtl/ovl_space_decoder.sv
module ovl_space_decoder
  import ovl_dec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [2**(ADDR_W-1)-1:0] OCC_MASK = '1,
  parameter logic [DATA_W-1:0] FILL_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuIndirect,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-2:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              dropWr
);
  accessStrobes_t strobes;

  ovl_dec_ctrl #(.ADDR_W(ADDR_W), .OCC_MASK(OCC_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuIndirect(cpuIndirect), .strobes(strobes)
  );

  ovl_dec_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL_VALUE(FILL_VALUE)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .regRdData(regRdData), .cpuRdData(cpuRdData),
    .dropWr(dropWr)
  );

  assign regRd     = strobes.regRd;
  assign regWr     = strobes.regWr;
  assign regAddr   = cpuAddr[ADDR_W-2:0];
  assign regWrData = cpuWrData;
endmodule

// File: tb/ovl_space_decoder_tb.sv
module ovl_space_decoder_tb;
  localparam logic [127:0] OCC = 128'h0000_0000_00FF_0000_0000_00F0_0000_000F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0, cpuIndirect = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData, regWrData, regRdData;
  logic regRd, regWr, dropWr;
  logic [6:0] regAddr;

  always #10 clk = ~clk;

  ovl_space_decoder #(.OCC_MASK(OCC)) u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuIndirect(cpuIndirect), .cpuRdData(cpuRdData),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .dropWr(dropWr)
  );

  // register-space peer
  logic [7:0] regArr [128];
  initial for (int i = 0; i < 128; i++) regArr[i] = 8'(i * 3 + 1);
  assign regRdData = regArr[regAddr];
  always @(posedge clk) if (regWr) regArr[regAddr] <= regWrData;

  int nChecks = 0, nFails = 0;
  bit checking = 0;
  int ramModel [256];
  logic [7:0] expRd = 8'h00;
  bit expDrop = 0;
  string rdTag = "R1";

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated at each active edge
  always @(posedge clk) begin
    if (!rstN) begin
      expRd = 8'h00; expDrop = 0; rdTag = "R1";
    end else if (checking) begin
      bit upper, toReg, occ;
      logic [7:0] a;
      a = cpuAddr;
      upper = a[7];
      toReg = upper && !cpuIndirect;
      occ = OCC[a[6:0]];
      chk(upper ? (toReg ? "R4" : "R3") : "R2", {7'd0, regRd}, {7'd0, cpuRd && toReg && occ});
      chk(toReg && !occ ? "R7" : "R8", {7'd0, regWr}, {7'd0, cpuWr && toReg && occ});
      if (regRd || regWr) chk("R4", {1'b0, regAddr}, {1'b0, a[6:0]});
      if (regWr) chk("R4", regWrData, cpuWrData);
      if (cpuRd) begin
        if (!toReg) begin
          expRd = 8'(ramModel[a]); rdTag = (cpuWr ? "R9" : (upper ? "R3" : "R2"));
        end else if (occ) begin
          expRd = regArr[a[6:0]]; rdTag = "R4";
        end else begin
          expRd = 8'h00; rdTag = "R6";
        end
      end else rdTag = "R5";
      if (cpuWr && !toReg) ramModel[a] = int'(cpuWrData);
      expDrop = cpuWr && toReg && !occ;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk(rdTag, cpuRdData, expRd);
      chk("R7", {7'd0, dropWr}, {7'd0, expDrop});
    end
  end

  task automatic acc(logic [7:0] a, bit ind, bit rd, bit wr, logic [7:0] d);
    cpuAddr = a; cpuIndirect = ind; cpuRd = rd; cpuWr = wr; cpuWrData = d;
    @(negedge clk);
  endtask

  task automatic idle();
    cpuRd = 0; cpuWr = 0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #4000000;
    nFails++;
    $display("FAIL watchdog: actual running expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cpuRdData, 8'h00);
    chk("R1", {7'd0, dropWr}, 8'h00);
    rstN = 1;
    @(negedge clk);
    chk("R1", cpuRdData, 8'h00);
    chk("R1", {7'd0, dropWr}, 8'h00);
    // fill whole RAM through both halves
    for (int i = 0; i < 256; i++) begin
      ramModel[i] = (i * 7 + 5) & 255;
      acc(8'(i), 1'b1, 1'b0, 1'b1, 8'(i * 7 + 5));
    end
    checking = 1;
    // R2 lower half, both modes
    acc(8'h10, 1'b0, 1'b1, 1'b0, 8'h00);
    acc(8'h10, 1'b1, 1'b1, 1'b0, 8'h00);
    acc(8'h7F, 1'b0, 1'b0, 1'b1, 8'h3C);
    acc(8'h7F, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(); idle();
    // R3/R4 same upper address in both spaces
    acc(8'h81, 1'b1, 1'b0, 1'b1, 8'hAA);
    acc(8'h81, 1'b0, 1'b0, 1'b1, 8'h55);
    acc(8'h81, 1'b1, 1'b1, 1'b0, 8'h00);
    acc(8'h81, 1'b0, 1'b1, 1'b0, 8'h00);
    acc(8'h81, 1'b1, 1'b1, 1'b0, 8'h00);
    // R6/R7 empty register address 90h
    acc(8'h90, 1'b1, 1'b0, 1'b1, 8'h12);
    acc(8'h90, 1'b0, 1'b0, 1'b1, 8'hEE);
    idle();
    acc(8'h90, 1'b0, 1'b1, 1'b0, 8'h00);
    acc(8'h90, 1'b1, 1'b1, 1'b0, 8'h00);
    // R9 read and write together
    acc(8'h20, 1'b0, 1'b1, 1'b1, 8'h99);
    acc(8'h20, 1'b0, 1'b1, 1'b0, 8'h00);
    acc(8'hA5, 1'b0, 1'b1, 1'b1, 8'h77);
    acc(8'hA5, 1'b0, 1'b1, 1'b0, 8'h00);
    idle(); idle();
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] ra;
      ra = 8'($urandom_range(0, 255));
      if (n % 3 == 0) ra = {1'b1, 2'b00, 5'($urandom_range(0, 7))};
      acc(ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
    end
    idle(); idle();
    finishRun();
  end
endmodule